// File: doc/BRIEF.md
# Conversion Window Comparator Interrupt

This block watches the stream of completed analog-to-digital conversions and checks the result of one channel, chosen by software, against a programmable window. The window is set by a 10-bit upper limit and a 10-bit lower limit. A result above the upper limit or below the lower limit raises a sticky status bit for that side. When the out-of-range interrupt is enabled, the same event also raises an out-of-range cause flag.

A mode bit chooses whether an out-of-range event also raises the conversion-complete cause flag. This lets a system send both kinds of event to one interrupt line or keep them on separate lines. A result equal to a limit counts as inside the window.

Every flag stays set until software clears it with a one-cycle clear pulse. Results from the other channels pass by without effect.

Top module: `adc_window_cmp`

## Requirements
- R1: A result is compared only in the cycle where `done_i` is 1, `cmp_en_i` is 1 and `done_ch_i` equals `cmp_sel_i`. Any other completion leaves all four flags unchanged.
- R2: A compared result strictly greater than `hi_lim_i` (unsigned) sets `hi_st_o` at the next clock edge.
- R3: A compared result strictly less than `lo_lim_i` (unsigned) sets `lo_st_o` at the next clock edge.
- R4: A compared result equal to either limit, and inside the window, sets no status bit and no cause flag.
- R5: An out-of-range event sets `oor_flag_o` only when `oor_irq_en_i` is 1. With the enable at 0, only the status bit is set.
- R6: An out-of-range event with `oor_irq_en_i` = 1 and `mode_i` = 0 also sets `cc_flag_o`.
- R7: With `mode_i` = 1, out-of-range events leave `cc_flag_o` unchanged, whether it is currently 0 or 1.
- R8: Each flag holds its value until its clear input is pulsed. A set and a clear of the same flag in the same cycle leave the flag at 1.
- R9: An active-low reset clears all four flags.
- R10: When the lower limit is above the upper limit, a result between the two sets both status bits at once.

Flag word used by the bench: {hi_st_o, lo_st_o, oor_flag_o, cc_flag_o}, with bit 3 being `hi_st_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| done_i | input | 1 | One-cycle strobe: a conversion has finished |
| done_ch_i | input | 3 | Channel index of the finished conversion |
| done_data_i | input | 10 | Result of the finished conversion |
| cmp_en_i | input | 1 | Window comparison enable |
| cmp_sel_i | input | 3 | Channel that is checked |
| hi_lim_i | input | 10 | Upper window limit |
| lo_lim_i | input | 10 | Lower window limit |
| oor_irq_en_i | input | 1 | Out-of-range interrupt enable |
| mode_i | input | 1 | 0: out-of-range also sets the completion cause; 1: it does not |
| clr_hi_i | input | 1 | Clear pulse for the upper status bit |
| clr_lo_i | input | 1 | Clear pulse for the lower status bit |
| clr_oor_i | input | 1 | Clear pulse for the out-of-range cause flag |
| clr_cc_i | input | 1 | Clear pulse for the completion cause flag |
| hi_st_o | output | 1 | Result was above the upper limit |
| lo_st_o | output | 1 | Result was below the lower limit |
| oor_flag_o | output | 1 | Out-of-range interrupt cause |
| cc_flag_o | output | 1 | Completion cause, set here by out-of-range events in mode 0 |

## Verification
The bench puts results exactly on each limit. A design that compares with `>=` or `<=` would raise a status bit there. It also uses full-scale values of 0 and 1023 against limits one step away, where a signed or truncated compare would choose the wrong side.

Completions from an unselected channel, and comparisons with the enable at 0, must leave every flag at 0. With the lower limit placed above the upper limit, both status bits must rise together.

Directed tests check the following:
- A completion cause flag that is already set survives a mode-1 event.
- A clear pulse that lands in the same cycle as a new event does not lose the event.
- Each clear input affects only its own flag.

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
  parameter int DW = 10,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [CW-1:0] done_ch_i,
  input  logic [DW-1:0] done_data_i,
  input  logic          cmp_en_i,
  input  logic [CW-1:0] cmp_sel_i,
  input  logic [DW-1:0] hi_lim_i,
  input  logic [DW-1:0] lo_lim_i,
  input  logic          oor_irq_en_i,
  input  logic          mode_i,
  input  logic          clr_hi_i,
  input  logic          clr_lo_i,
  input  logic          clr_oor_i,
  input  logic          clr_cc_i,
  output logic          hi_st_o,
  output logic          lo_st_o,
  output logic          oor_flag_o,
  output logic          cc_flag_o
);

  logic hit, above, below, evt, any_clr;

  assign hit     = done_i && cmp_en_i && (done_ch_i == cmp_sel_i);
  assign above   = hit && (done_data_i > hi_lim_i);
  assign below   = hit && (done_data_i < lo_lim_i);
  assign evt     = above || below;
  assign any_clr = clr_hi_i || clr_lo_i || clr_oor_i || clr_cc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_st_o    <= 1'b0;
      lo_st_o    <= 1'b0;
      oor_flag_o <= 1'b0;
      cc_flag_o  <= 1'b0;
    end else begin
      hi_st_o    <= above || (hi_st_o && !clr_hi_i);
      lo_st_o    <= below || (lo_st_o && !clr_lo_i);
      oor_flag_o <= (evt && oor_irq_en_i) || (oor_flag_o && !clr_oor_i);
      cc_flag_o  <= (evt && oor_irq_en_i && !mode_i) || (cc_flag_o && !clr_cc_i);
    end
  end

  AST_SKIP_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !(cmp_en_i && done_ch_i == cmp_sel_i) && !any_clr)
      |=> $stable({hi_st_o, lo_st_o, oor_flag_o, cc_flag_o})); // R1
  AST_UPPER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && cmp_en_i && done_ch_i == cmp_sel_i && done_data_i > hi_lim_i) |=> hi_st_o); // R2
  AST_LOWER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && cmp_en_i && done_ch_i == cmp_sel_i && done_data_i < lo_lim_i) |=> lo_st_o); // R3
  AST_INSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_data_i <= hi_lim_i && done_data_i >= lo_lim_i && !any_clr)
      |=> $stable({hi_st_o, lo_st_o, oor_flag_o, cc_flag_o})); // R4
  AST_OOR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_st_o || lo_st_o) && $rose(hi_st_o || lo_st_o) && $past(oor_irq_en_i)) |-> oor_flag_o); // R5
  AST_MODE1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !clr_cc_i) |=> $stable(cc_flag_o)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !any_clr) |=> $stable({hi_st_o, lo_st_o, oor_flag_o, cc_flag_o})); // R8

endmodule

// File: tb/adc_window_cmp_tb.sv
module adc_window_cmp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done = 1'b0, en = 1'b0, irq = 1'b0, mode = 1'b0;
  logic [2:0] ch = '0, sel = '0;
  logic [9:0] data = '0, hi = '0, lo = '0;
  logic chi = 1'b0, clo = 1'b0, coor = 1'b0, ccc = 1'b0;
  logic hs, ls, of, cf;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  adc_window_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .done_i(done), .done_ch_i(ch), .done_data_i(data),
    .cmp_en_i(en), .cmp_sel_i(sel), .hi_lim_i(hi), .lo_lim_i(lo),
    .oor_irq_en_i(irq), .mode_i(mode), .clr_hi_i(chi), .clr_lo_i(clo),
    .clr_oor_i(coor), .clr_cc_i(ccc), .hi_st_o(hs), .lo_st_o(ls),
    .oor_flag_o(of), .cc_flag_o(cf));

  // fields: ch[42:40] data[39:30] en[29] sel[28:26] hi[25:16] lo[15:6] irq[5] mode[4] exp{hi,lo,oor,cc}[3:0]
  localparam int NV = 12;
  localparam logic [42:0] VEC [0:NV-1] = '{
    {3'd2, 10'd600,  1'b1, 3'd2, 10'd500,  10'd100, 1'b1, 1'b0, 4'b1011},
    {3'd2, 10'd50,   1'b1, 3'd2, 10'd500,  10'd100, 1'b1, 1'b0, 4'b0111},
    {3'd2, 10'd500,  1'b1, 3'd2, 10'd500,  10'd100, 1'b1, 1'b0, 4'b0000},
    {3'd2, 10'd100,  1'b1, 3'd2, 10'd500,  10'd100, 1'b1, 1'b0, 4'b0000},
    {3'd3, 10'd600,  1'b1, 3'd2, 10'd500,  10'd100, 1'b1, 1'b0, 4'b0000},
    {3'd2, 10'd600,  1'b0, 3'd2, 10'd500,  10'd100, 1'b1, 1'b0, 4'b0000},
    {3'd2, 10'd600,  1'b1, 3'd2, 10'd500,  10'd100, 1'b0, 1'b0, 4'b1000},
    {3'd2, 10'd600,  1'b1, 3'd2, 10'd500,  10'd100, 1'b1, 1'b1, 4'b1010},
    {3'd5, 10'd1023, 1'b1, 3'd5, 10'd1022, 10'd0,   1'b1, 1'b1, 4'b1010},
    {3'd5, 10'd0,    1'b1, 3'd5, 10'd1023, 10'd1,   1'b1, 1'b0, 4'b0111},
    {3'd7, 10'd300,  1'b1, 3'd7, 10'd200,  10'd400, 1'b1, 1'b0, 4'b1111},
    {3'd0, 10'd0,    1'b1, 3'd0, 10'd0,    10'd0,   1'b1, 1'b0, 4'b0000}
  };
  string vtag [NV];

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s flags=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); {chi, clo, coor, ccc} = 4'b1111;
    @(negedge clk); {chi, clo, coor, ccc} = 4'b0000;
  endtask

  task automatic strobe(input logic [2:0] c, input logic [9:0] d);
    @(negedge clk); ch = c; data = d; done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    vtag = '{"R2 R5 R6", "R3 R5 R6", "R4 upper", "R4 lower", "R1 channel",
             "R1 enable", "R5 irq off", "R7 mode1", "R2 full scale", "R3 zero",
             "R10 inverted", "R4 zero window"};
    repeat (3) @(negedge clk);
    chk("R9 reset", {hs, ls, of, cf}, 4'b0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      clear_all();
      {en, sel, hi, lo, irq, mode} = {VEC[i][29], VEC[i][28:26], VEC[i][25:16],
                                      VEC[i][15:6], VEC[i][5], VEC[i][4]};
      strobe(VEC[i][42:40], VEC[i][39:30]);
      chk(vtag[i], {hs, ls, of, cf}, VEC[i][3:0]);
    end

    // R8 sticky over idle cycles, then per-flag clear
    clear_all();
    en = 1; sel = 1; hi = 10'd200; lo = 10'd100; irq = 1; mode = 0;
    strobe(3'd1, 10'd900);
    repeat (4) @(negedge clk);
    chk("R8 sticky", {hs, ls, of, cf}, 4'b1011);
    chi = 1; @(negedge clk); chi = 0;
    chk("R8 clear hi only", {hs, ls, of, cf}, 4'b0011);
    ccc = 1; @(negedge clk); ccc = 0;
    chk("R8 clear cc only", {hs, ls, of, cf}, 4'b0010);

    // R7 cc already set stays through mode-1 event
    clear_all();
    strobe(3'd1, 10'd900);
    mode = 1; chi = 1; coor = 1; @(negedge clk); chi = 0; coor = 0;
    strobe(3'd1, 10'd5);
    chk("R7 cc kept", {hs, ls, of, cf}, 4'b0111);

    // R8 set wins over clear in the same cycle
    clear_all();
    mode = 0;
    @(negedge clk); ch = 1; data = 10'd900; done = 1; chi = 1; coor = 1;
    @(negedge clk); done = 0; chi = 0; coor = 0;
    chk("R8 set beats clear", {hs, ls, of, cf}, 4'b1011);

    // R9 reset clears set flags
    rst_n = 0; @(negedge clk);
    chk("R9 reset mid-run", {hs, ls, of, cf}, 4'b0000);
    rst_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule